// File: doc/BRIEF.md
# Audio Serial Port Clock Master Generator

This block sits beside a two-port audio serial interface, one port that receives samples and one that sends them. From a single master clock it builds the bit clock and the frame clock for whichever port is picked as clock master. The other port is left as a slave, with its clock drivers disabled. A 3-bit mode code selects the master port and the master-clock-to-sample-rate ratio. The code can also leave both ports as slaves or select the matched-phase arrangement, and in both of those cases no clocks are driven.

Each frame holds 64 bit-clock periods. The bit clock is the master clock divided by 4, 8 or 12, for ratios of 256, 512 and 768 times the sample rate. The frame clock changes only on falling edges of the bit clock, so a receiver can capture data on rising edges. A per-port format code sets the frame-clock polarity. On the sending port the format code can also select TDM, in which the frame clock is replaced by a pulse one bit-clock wide. The block has no data path, so it has no valid/ready interface and all of its pins are plain control pins.

Top module: `aud_clkgen`

## Requirements
- R1: Mode 000 (both slaves) and mode 100 (matched phase) hold both clock-enable outputs low.
- R2: Modes 001, 010 and 011 make the sending port master. Modes 101, 110 and 111 make the receiving port master. The two enables are never high together.
- R3: The low two mode bits set the bit-clock divide: 01 divides by 12 (768×fs), 10 by 8 (512×fs) and 11 by 4 (256×fs). The bit clock has a 50% duty cycle, and after a restart its first half-period is low.
- R4: The frame clock repeats every 64 bit-clock periods and changes only in the master-clock cycle in which the bit clock falls.
- R5: Format code 00 (left-justified) and 10 (right-justified) drive the frame clock high during the left half, which is bit periods 0 to 31. Format code 01 (I2S) drives it low during that half.
- R6: On the sending port, format code 11 (TDM) drives the frame clock high during bit period 0 of each frame only. On the receiving port, code 11 is handled as left-justified.
- R7: A port that is not master drives its enable, bit clock and frame clock low, and its dividers are held at zero.
- R8: While synchronous reset is high, all dividers are cleared. Counting resumes from bit period 0 of a left half.
- R9: A change of the mode code restarts all dividers in the next master-clock cycle. The first frame at the new setting begins with a full left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Master/ratio selection code |
| rx_fmt_i | input | 2 | Receiving port format code |
| tx_fmt_i | input | 2 | Sending port format code |
| rx_clk_oe_o | output | 1 | Receiving port clock drivers enabled |
| rx_sclk_o | output | 1 | Receiving port bit clock |
| rx_lrclk_o | output | 1 | Receiving port frame clock |
| tx_clk_oe_o | output | 1 | Sending port clock drivers enabled |
| tx_sclk_o | output | 1 | Sending port bit clock |
| tx_lrclk_o | output | 1 | Sending port frame clock or TDM frame pulse |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a frame. It requires the dividers to be at an arbitrary non-zero phase at the moment the code changes. The test must then show that the new master begins with a full left half at a different divide ratio. The bench produces this case by running one mode for part of a frame and then rewriting the mode code without a reset. From that edge it checks every cycle against an arithmetic model. Before that, a sweep over all eight mode codes and all four format codes checks two full frames per master setting, cycle by cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  // Encoding mirrors the low two bits of the mode code.
  typedef enum logic [1:0] {
    RAT_NONE = 2'd0,
    RAT_HI   = 2'd1,
    RAT_MID  = 2'd2,
    RAT_LO   = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   en;
    ratio_e ratio;
  } port_cfg_t;
endpackage

// File: rtl/aclk_mode_dec.sv
module aclk_mode_dec
  import aclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] mode_i,
  output logic       restart_o,
  output port_cfg_t  rx_cfg_o,
  output port_cfg_t  tx_cfg_o
);
  logic [2:0] mode_q;

  always_ff @(posedge clk_i) begin
    mode_q <= mode_i;
  end

  assign restart_o = rst_i || (mode_i != mode_q);

  always_comb begin
    rx_cfg_o = '{en: 1'b0, ratio: RAT_NONE};
    tx_cfg_o = '{en: 1'b0, ratio: RAT_NONE};
    if (mode_q[1:0] != 2'b00) begin
      if (mode_q[2]) begin
        rx_cfg_o.en    = 1'b1;
        rx_cfg_o.ratio = ratio_e'(mode_q[1:0]);
      end else begin
        tx_cfg_o.en    = 1'b1;
        tx_cfg_o.ratio = ratio_e'(mode_q[1:0]);
      end
    end
  end

  a_r2_one_master: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rx_cfg_o.en && tx_cfg_o.en));
endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
  import aclk_pkg::*;
#(
  parameter int unsigned RATIO_LO       = 256,
  parameter int unsigned RATIO_MID      = 512,
  parameter int unsigned RATIO_HI       = 768,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic   clk_i,
  input  logic   clr_i,
  input  logic   run_i,
  input  ratio_e ratio_i,
  output logic   sclk_o,
  output logic   wrap_o
);
  localparam int unsigned DIV_LO  = RATIO_LO / BITS_PER_FRAME;
  localparam int unsigned DIV_MID = RATIO_MID / BITS_PER_FRAME;
  localparam int unsigned DIV_HI  = RATIO_HI / BITS_PER_FRAME;
  localparam int unsigned CW      = $clog2(DIV_HI + 1);

  logic [CW-1:0] len;
  logic [CW-1:0] cnt_q;

  always_comb begin
    unique case (ratio_i)
      RAT_HI:  len = CW'(DIV_HI);
      RAT_MID: len = CW'(DIV_MID);
      RAT_LO:  len = CW'(DIV_LO);
      default: len = CW'(DIV_LO);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (clr_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == len - CW'(1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sclk_o = run_i && (cnt_q >= (len >> 1));
  assign wrap_o = run_i && (cnt_q == len - CW'(1));

  a_r3_sclk_rise_mid: assert property (@(posedge clk_i) disable iff (clr_i)
    (run_i && $rose(sclk_o)) |-> (cnt_q == (len >> 1)));
  a_r7_held_zero: assert property (@(posedge clk_i) disable iff (clr_i)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/aclk_frame_gen.sv
module aclk_frame_gen
  import aclk_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter bit          TDM_OK         = 1'b0
) (
  input  logic       clk_i,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       wrap_i,
  input  logic [1:0] fmt_i,
  output logic       lrclk_o
);
  localparam int unsigned BW   = $clog2(BITS_PER_FRAME);
  localparam int unsigned HALF = BITS_PER_FRAME / 2;

  logic [BW-1:0] bit_q;
  fmt_e          fmt;

  assign fmt = fmt_e'(fmt_i);

  always_ff @(posedge clk_i) begin
    if (clr_i || !run_i) begin
      bit_q <= '0;
    end else if (wrap_i) begin
      bit_q <= (bit_q == BW'(BITS_PER_FRAME - 1)) ? '0 : bit_q + BW'(1);
    end
  end

  generate
    if (TDM_OK) begin : g_tdm
      always_comb begin
        if (!run_i)              lrclk_o = 1'b0;
        else if (fmt == FMT_TDM) lrclk_o = (bit_q == '0);
        else if (fmt == FMT_I2S) lrclk_o = (bit_q >= BW'(HALF));
        else                     lrclk_o = (bit_q < BW'(HALF));
      end
    end else begin : g_plain
      always_comb begin
        if (!run_i)              lrclk_o = 1'b0;
        else if (fmt == FMT_I2S) lrclk_o = (bit_q >= BW'(HALF));
        else                     lrclk_o = (bit_q < BW'(HALF));
      end
    end
  endgenerate
endmodule

// File: rtl/aclk_port.sv
module aclk_port
  import aclk_pkg::*;
#(
  parameter int unsigned RATIO_LO       = 256,
  parameter int unsigned RATIO_MID      = 512,
  parameter int unsigned RATIO_HI       = 768,
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter bit          TDM_OK         = 1'b0
) (
  input  logic       clk_i,
  input  logic       clr_i,
  input  port_cfg_t  cfg_i,
  input  logic [1:0] fmt_i,
  output logic       oe_o,
  output logic       sclk_o,
  output logic       lrclk_o
);
  logic wrap;

  aclk_bit_div #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .BITS_PER_FRAME(BITS_PER_FRAME)
  ) u_div (
    .clk_i(clk_i), .clr_i(clr_i), .run_i(cfg_i.en), .ratio_i(cfg_i.ratio),
    .sclk_o(sclk_o), .wrap_o(wrap)
  );

  aclk_frame_gen #(
    .BITS_PER_FRAME(BITS_PER_FRAME), .TDM_OK(TDM_OK)
  ) u_frm (
    .clk_i(clk_i), .clr_i(clr_i), .run_i(cfg_i.en), .wrap_i(wrap),
    .fmt_i(fmt_i), .lrclk_o(lrclk_o)
  );

  assign oe_o = cfg_i.en;

  a_r4_lr_on_fall: assert property (@(posedge clk_i) disable iff (clr_i)
    ($past(oe_o) && oe_o && !$past(clr_i) && (lrclk_o != $past(lrclk_o)))
      |-> ($past(sclk_o) && !sclk_o));
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aclk_pkg::*;
#(
  parameter int unsigned RATIO_LO       = 256,
  parameter int unsigned RATIO_MID      = 512,
  parameter int unsigned RATIO_HI       = 768,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] mode_i,
  input  logic [1:0] rx_fmt_i,
  input  logic [1:0] tx_fmt_i,
  output logic       rx_clk_oe_o,
  output logic       rx_sclk_o,
  output logic       rx_lrclk_o,
  output logic       tx_clk_oe_o,
  output logic       tx_sclk_o,
  output logic       tx_lrclk_o
);
  logic      restart;
  port_cfg_t rx_cfg;
  port_cfg_t tx_cfg;

  aclk_mode_dec u_dec (
    .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i),
    .restart_o(restart), .rx_cfg_o(rx_cfg), .tx_cfg_o(tx_cfg)
  );

  aclk_port #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .BITS_PER_FRAME(BITS_PER_FRAME), .TDM_OK(1'b0)
  ) u_rx (
    .clk_i(clk_i), .clr_i(restart), .cfg_i(rx_cfg), .fmt_i(rx_fmt_i),
    .oe_o(rx_clk_oe_o), .sclk_o(rx_sclk_o), .lrclk_o(rx_lrclk_o)
  );

  aclk_port #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .BITS_PER_FRAME(BITS_PER_FRAME), .TDM_OK(1'b1)
  ) u_tx (
    .clk_i(clk_i), .clr_i(restart), .cfg_i(tx_cfg), .fmt_i(tx_fmt_i),
    .oe_o(tx_clk_oe_o), .sclk_o(tx_sclk_o), .lrclk_o(tx_lrclk_o)
  );

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rx_clk_oe_o |-> (!rx_sclk_o && !rx_lrclk_o)) and
    (!tx_clk_oe_o |-> (!tx_sclk_o && !tx_lrclk_o)));
  a_r1_no_master: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(mode_i) == mode_i && mode_i[1:0] == 2'b00) |=>
      (!rx_clk_oe_o && !tx_clk_oe_o));
endmodule

// File: tb/sim_aud_clkgen.sv
module sim_aud_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic [1:0] rx_fmt = 2'd0;
  logic [1:0] tx_fmt = 2'd0;
  logic rx_oe, rx_sclk, rx_lr, tx_oe, tx_sclk, tx_lr;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aud_clkgen u0 (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .rx_fmt_i(rx_fmt), .tx_fmt_i(tx_fmt),
    .rx_clk_oe_o(rx_oe), .rx_sclk_o(rx_sclk), .rx_lrclk_o(rx_lr),
    .tx_clk_oe_o(tx_oe), .tx_sclk_o(tx_sclk), .tx_lrclk_o(tx_lr)
  );

  // Expected {oe, sclk, lrclk} for one port, k cycles after a restart edge.
  function automatic logic [2:0] model(input logic [2:0] m, input logic [1:0] f,
                                       input bit is_tx, input int k);
    bit master;
    int dv, bitn;
    logic s, l;
    master = (m[1:0] != 2'b00) && (m[2] == !is_tx);
    if (!master) return 3'b000;
    dv   = (m[1:0] == 2'd1) ? 768 / 64 : (m[1:0] == 2'd2) ? 512 / 64 : 256 / 64;
    s    = ((k % dv) >= dv / 2);
    bitn = (k / dv) % 64;
    if (is_tx && f == 2'd3) l = (bitn == 0);
    else if (f == 2'd1)     l = (bitn >= 32);
    else                    l = (bitn < 32);
    return {1'b1, s, l};
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s mode=%0d actual=%b expected=%b", tag, mode, act, exp);
    end
  endtask

  // Sample n cycles from the restart edge; optionally release reset after k=0.
  task automatic window(input int n, input string tag0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(k == 0 ? tag0 : "R2 R3 R4 R5 R6 R7 rx",
            {rx_oe, rx_sclk, rx_lr}, model(mode, rx_fmt, 1'b0, k));
      check(k == 0 ? tag0 : "R2 R3 R4 R5 R6 R7 tx",
            {tx_oe, tx_sclk, tx_lr}, model(mode, tx_fmt, 1'b1, k));
      if (k == 0) rst = 1'b0;
    end
  endtask

  function automatic int frame_cycles(input logic [2:0] m);
    if (m[1:0] == 2'd0) return 200;
    return 2 * 64 * ((m[1:0] == 2'd1) ? 12 : (m[1:0] == 2'd2) ? 8 : 4) + 7;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8 reset and R1..R7 sweep over every mode and format
    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 8; m++) begin
        @(negedge clk);
        rst = 1'b1; mode = 3'(m); rx_fmt = 2'(f); tx_fmt = 2'(f);
        @(posedge clk);
        window(frame_cycles(3'(m)), "R8 reset restart");
      end
    end
    // R1 matched phase, stated explicitly
    @(negedge clk); mode = 3'b100;
    @(posedge clk);
    window(50, "R1 matched phase");
    // R9 mid-frame mode change: sending master, then receiving master
    for (int f = 0; f < 3; f++) begin
      @(negedge clk); mode = 3'b011; rx_fmt = 2'(f); tx_fmt = 2'(2 - f);
      @(posedge clk);
      window(37 + 41 * f, "R9 change in");
      @(negedge clk); mode = 3'b101;
      @(posedge clk);
      window(frame_cycles(3'b101), "R9 restart to receiver");
      @(negedge clk); mode = 3'b010; tx_fmt = 2'd3;
      @(posedge clk);
      window(frame_cycles(3'b010), "R9 restart to sender TDM R6");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule